// File: doc/BRIEF.md
# Fixed-Point Add Execution Unit

This block is the integer add stage of a 64-bit RISC core. On each cycle where `issue_i` is high, it decodes the 32-bit instruction word. If the word belongs to the add family, it computes the sum of the two source operands and any selected carry-in. One clock edge later it presents the result, the destination register index and, for record forms, a four-bit condition field.

The unit holds the five fixed-point exception bits itself: primary carry, 32-bit carry, overflow, 32-bit overflow and sticky summary overflow. The family has six members:

- plain add
- add carrying
- add extended
- add extended with minus one
- add extended with zero
- an extended add with an alternate carry chain

The alternate carry chain reads its carry from the overflow bit and writes its carry-out back to the overflow bits. The primary carry and summary bits are left alone. This lets two independent multi-word additions be interleaved.

A 32-bit-mode input moves the carry and overflow tap points to the 32-bit boundary. An ISA-level input enables the 32-bit carry copies and the alternate chain. Words outside the family are ignored. Bad encodings of the alternate add raise an illegal flag and change nothing.

Top module: `fxadd_unit`

## Requirements
- R1: Bits are numbered here with bit 0 as the LSB. A word is in the family only when insn[31:26] = 31. Within that, the 9-bit field insn[9:1] selects the operation: 266 is plain add, 10 is add carrying, 138 is add extended, 234 is extended with minus one, and 202 is extended with zero. insn[10] is the overflow-enable bit, insn[0] the record bit, and insn[25:21] the destination. Any other word yields no result, no illegal flag and no change to the exception bits.
- R2: The result is A + B + cin modulo 2^64. B is replaced by all ones for the minus-one form and by zero for the zero form. cin is 0 for plain add and add carrying, the primary carry bit for the three extended forms, and the overflow bit for the alternate form.
- R3: The four carrying forms (add carrying and the three extended forms) write the carry bit. In 64-bit mode it takes the carry out of bit 63; in 32-bit mode it takes the carry into bit 32. When the ISA-level input is high, the 32-bit carry bit takes the carry into bit 32 (bit 32 of A xor B xor result); otherwise it is held.
- R4: Plain add, with or without overflow enable, neither reads nor writes either carry bit.
- R5: The alternate add is recognised by insn[8:1] = 170, with a 2-bit CY field at insn[10:9]. It writes its carry-out (chosen by mode as in R3) to the overflow bit and the carry into bit 32 to the 32-bit overflow bit. It leaves both carry bits and the summary bit unchanged.
- R6: The alternate add with CY ≠ 0, with insn[0] = 1, or with the ISA-level input low raises `illegal_o` one cycle later. In that case there is no result and no exception bit changes.
- R7: Overflow-enabled forms other than the alternate add set the overflow bit on signed overflow: 64-bit overflow in 64-bit mode, 32-bit overflow in 32-bit mode. When the ISA-level input is high, the 32-bit overflow bit takes the signed 32-bit overflow. The summary bit is set whenever the new overflow bit is 1 and is otherwise held.
- R8: Record forms raise `cr0_we_o` and drive `cr0_o`, where bit 3 = negative, bit 2 = positive, bit 1 = zero and bit 0 = the updated summary bit. In 32-bit mode the sign and zero tests use the sign-extended low 32 bits of the result.
- R9: All outputs are registered and appear one clock after issue. When there is no valid result, `res_o`, `rt_o` and `cr0_o` read zero. Reset clears every output and every exception bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Instruction word and operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| opa_i | input | 64 | First source operand |
| opb_i | input | 64 | Second source operand |
| mode32_i | input | 1 | 32-bit computation mode |
| isa300_i | input | 1 | ISA level with 32-bit carries and the alternate add |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 64 | Sum |
| rt_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Illegal encoding of the alternate add |
| cr0_we_o | output | 1 | Condition field write enable |
| cr0_o | output | 4 | Negative, positive, zero, summary |
| xer_ca_o | output | 1 | Carry bit |
| xer_ca32_o | output | 1 | 32-bit carry bit |
| xer_ov_o | output | 1 | Overflow bit |
| xer_ov32_o | output | 1 | 32-bit overflow bit |
| xer_so_o | output | 1 | Summary overflow bit |

## Verification
The bench builds the unit with its default 64-bit data width. At that width, both carry tap points exist together: the carry out of bit 63 and the carry into bit 32. Switching the mode input per instruction can then separate them with operands such as 0x00000000_FFFFFFFF + 1. The random phase mixes both ISA levels and both modes with all six operations and their flag variants. That mix lets carry and overflow state from one chain feed the next instruction of the other chain.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

  localparam int REG_IDX_W = 5;

  localparam logic [5:0] PRI_ARITH = 6'd31;
  localparam logic [8:0] XO_PLAIN  = 9'd266;
  localparam logic [8:0] XO_CARRY  = 9'd10;
  localparam logic [8:0] XO_EXT    = 9'd138;
  localparam logic [8:0] XO_EXTM1  = 9'd234;
  localparam logic [8:0] XO_EXTZ   = 9'd202;
  localparam logic [7:0] XO_ALT    = 8'd170;

  typedef enum logic [2:0] {
    OPK_PLAIN,
    OPK_CARRY,
    OPK_EXT,
    OPK_EXTM1,
    OPK_EXTZ,
    OPK_ALT
  } opk_e;

  typedef struct packed {
    logic                 hit;
    logic                 fault;
    opk_e                 kind;
    logic                 oe;
    logic                 rc;
    logic [REG_IDX_W-1:0] rt;
  } dec_t;

  typedef struct packed {
    logic ca;
    logic ca32;
    logic ov;
    logic ov32;
    logic so;
  } xer_t;

endpackage

// File: rtl/fxadd_decode.sv
module fxadd_decode
  import fxadd_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] insn_i,
  input  logic          isa300_i,
  output dec_t          dec_o
);

  localparam int PRI_LSB = IW - 6;
  localparam int RT_LSB  = PRI_LSB - REG_IDX_W;
  localparam int RC_BIT  = 0;
  localparam int XO_LSB  = 1;
  localparam int OE_BIT  = 10;
  localparam int CY_LSB  = 9;

  always_comb begin
    dec_o      = '0;
    dec_o.kind = OPK_PLAIN;
    dec_o.rt   = insn_i[RT_LSB +: REG_IDX_W];
    dec_o.oe   = insn_i[OE_BIT];
    dec_o.rc   = insn_i[RC_BIT];
    if (insn_i[PRI_LSB +: 6] == PRI_ARITH) begin
      if (insn_i[XO_LSB +: 8] == XO_ALT) begin
        dec_o.hit   = 1'b1;
        dec_o.kind  = OPK_ALT;
        dec_o.oe    = 1'b0;
        dec_o.rc    = 1'b0;
        dec_o.fault = (insn_i[CY_LSB +: 2] != 2'd0) || insn_i[RC_BIT] || !isa300_i;
      end else begin
        unique case (insn_i[XO_LSB +: 9])
          XO_PLAIN: begin dec_o.hit = 1'b1; dec_o.kind = OPK_PLAIN; end
          XO_CARRY: begin dec_o.hit = 1'b1; dec_o.kind = OPK_CARRY; end
          XO_EXT:   begin dec_o.hit = 1'b1; dec_o.kind = OPK_EXT;   end
          XO_EXTM1: begin dec_o.hit = 1'b1; dec_o.kind = OPK_EXTM1; end
          XO_EXTZ:  begin dec_o.hit = 1'b1; dec_o.kind = OPK_EXTZ;  end
          default:  dec_o.hit = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/fxadd_adder.sv
module fxadd_adder
  import fxadd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  opk_e            kind_i,
  input  logic            ca_i,
  input  logic            ov_i,
  input  logic            mode32_i,
  output logic [XLEN-1:0] sum_o,
  output logic            cout_o,
  output logic            c32_o,
  output logic            sov_wide_o,
  output logic            sov_half_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_eff;
  logic            cin;
  logic            cout_wide;
  logic [XLEN-1:0] bit_carries;

  always_comb begin
    unique case (kind_i)
      OPK_EXTM1: b_eff = '1;
      OPK_EXTZ:  b_eff = '0;
      default:   b_eff = b_i;
    endcase
    unique case (kind_i)
      OPK_EXT, OPK_EXTM1, OPK_EXTZ: cin = ca_i;
      OPK_ALT:                      cin = ov_i;
      default:                      cin = 1'b0;
    endcase
  end

  assign {cout_wide, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, cin};
  assign bit_carries        = a_i ^ b_eff ^ sum_o;
  assign c32_o              = bit_carries[HALF];
  assign cout_o             = mode32_i ? bit_carries[HALF] : cout_wide;
  assign sov_wide_o = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
  assign sov_half_o = (a_i[HALF-1] == b_eff[HALF-1]) && (sum_o[HALF-1] != a_i[HALF-1]);

endmodule

// File: rtl/fxadd_xer.sv
module fxadd_xer
  import fxadd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  opk_e kind_i,
  input  logic oe_i,
  input  logic isa300_i,
  input  logic mode32_i,
  input  logic cout_i,
  input  logic c32_i,
  input  logic sov_wide_i,
  input  logic sov_half_i,
  output xer_t xer_q_o,
  output xer_t xer_d_o
);

  xer_t q;
  xer_t d;

  always_comb begin
    d = q;
    if (take_i) begin
      unique case (kind_i)
        OPK_CARRY, OPK_EXT, OPK_EXTM1, OPK_EXTZ: begin
          d.ca = cout_i;
          if (isa300_i) d.ca32 = c32_i;
        end
        OPK_ALT: begin
          d.ov = cout_i;
          if (isa300_i) d.ov32 = c32_i;
        end
        default: ;
      endcase
      if (oe_i && (kind_i != OPK_ALT)) begin
        d.ov = mode32_i ? sov_half_i : sov_wide_i;
        if (isa300_i) d.ov32 = sov_half_i;
        if (d.ov) d.so = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  assign xer_q_o = q;
  assign xer_d_o = d;

endmodule

// File: rtl/fxadd_unit.sv
module fxadd_unit
  import fxadd_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_i,
  input  logic [IW-1:0]        insn_i,
  input  logic [XLEN-1:0]      opa_i,
  input  logic [XLEN-1:0]      opb_i,
  input  logic                 mode32_i,
  input  logic                 isa300_i,
  output logic                 res_valid_o,
  output logic [XLEN-1:0]      res_o,
  output logic [REG_IDX_W-1:0] rt_o,
  output logic                 illegal_o,
  output logic                 cr0_we_o,
  output logic [3:0]           cr0_o,
  output logic                 xer_ca_o,
  output logic                 xer_ca32_o,
  output logic                 xer_ov_o,
  output logic                 xer_ov32_o,
  output logic                 xer_so_o
);

  localparam int HALF = XLEN / 2;

  dec_t            dec;
  xer_t            xer_q;
  xer_t            xer_d;
  logic [XLEN-1:0] sum;
  logic            cout;
  logic            c32;
  logic            sov_wide;
  logic            sov_half;
  logic            take;
  logic            fault;
  logic [XLEN-1:0] cmp_val;
  logic [3:0]      cr0_d;

  fxadd_decode #(.IW(IW)) u_decode (
    .insn_i   (insn_i),
    .isa300_i (isa300_i),
    .dec_o    (dec)
  );

  fxadd_adder #(.XLEN(XLEN)) u_adder (
    .a_i        (opa_i),
    .b_i        (opb_i),
    .kind_i     (dec.kind),
    .ca_i       (xer_q.ca),
    .ov_i       (xer_q.ov),
    .mode32_i   (mode32_i),
    .sum_o      (sum),
    .cout_o     (cout),
    .c32_o      (c32),
    .sov_wide_o (sov_wide),
    .sov_half_o (sov_half)
  );

  assign take  = issue_i && dec.hit && !dec.fault;
  assign fault = issue_i && dec.hit && dec.fault;

  fxadd_xer u_xer (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take),
    .kind_i     (dec.kind),
    .oe_i       (dec.oe),
    .isa300_i   (isa300_i),
    .mode32_i   (mode32_i),
    .cout_i     (cout),
    .c32_i      (c32),
    .sov_wide_i (sov_wide),
    .sov_half_i (sov_half),
    .xer_q_o    (xer_q),
    .xer_d_o    (xer_d)
  );

  always_comb begin
    cmp_val = mode32_i ? {{HALF{sum[HALF-1]}}, sum[HALF-1:0]} : sum;
    cr0_d[3] = cmp_val[XLEN-1];
    cr0_d[1] = (cmp_val == '0);
    cr0_d[2] = !cmp_val[XLEN-1] && (cmp_val != '0);
    cr0_d[0] = xer_d.so;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
      rt_o        <= '0;
      illegal_o   <= 1'b0;
      cr0_we_o    <= 1'b0;
      cr0_o       <= '0;
    end else begin
      res_valid_o <= take;
      res_o       <= take ? sum : '0;
      rt_o        <= take ? dec.rt : '0;
      illegal_o   <= fault;
      cr0_we_o    <= take && dec.rc;
      cr0_o       <= (take && dec.rc) ? cr0_d : 4'd0;
    end
  end

  assign xer_ca_o   = xer_q.ca;
  assign xer_ca32_o = xer_q.ca32;
  assign xer_ov_o   = xer_q.ov;
  assign xer_ov32_o = xer_q.ov32;
  assign xer_so_o   = xer_q.so;

endmodule

// File: rtl/fxadd_chk.sv
module fxadd_chk #(
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_i,
  input logic [IW-1:0] insn_i,
  input logic          isa300_i,
  input logic          res_valid_o,
  input logic          illegal_o,
  input logic          cr0_we_o,
  input logic [3:0]    cr0_o,
  input logic          xer_ca_o,
  input logic          xer_ca32_o,
  input logic          xer_ov_o,
  input logic          xer_ov32_o,
  input logic          xer_so_o
);

  logic arith_pri;
  logic alt_ok;
  logic plain_op;

  assign arith_pri = (insn_i[IW-1 -: 6] == 6'd31);
  assign alt_ok    = arith_pri && (insn_i[8:1] == 8'd170) && (insn_i[10:9] == 2'd0)
                     && !insn_i[0] && isa300_i;
  assign plain_op  = arith_pri && (insn_i[9:1] == 9'd266);

  // R4
  plain_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_i && plain_op) |=> ($stable(xer_ca_o) && $stable(xer_ca32_o)));

  // R5
  alt_keeps_ca_so_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_i && alt_ok) |=> ($stable(xer_ca_o) && $stable(xer_ca32_o) && $stable(xer_so_o)));

  // R6
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!res_valid_o && $stable(xer_ca_o) && $stable(xer_ca32_o)
                   && $stable(xer_ov_o) && $stable(xer_ov32_o) && $stable(xer_so_o)));

  // R7
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(xer_so_o));

  // R8
  cr0_so_chk: assert property (@(posedge clk) disable iff (rst)
    cr0_we_o |-> (res_valid_o && (cr0_o[0] == xer_so_o) && $onehot(cr0_o[3:1])));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> (!res_valid_o && !illegal_o && !cr0_we_o));

endmodule

bind fxadd_unit fxadd_chk #(.IW(IW)) u_fxadd_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_i     (issue_i),
  .insn_i      (insn_i),
  .isa300_i    (isa300_i),
  .res_valid_o (res_valid_o),
  .illegal_o   (illegal_o),
  .cr0_we_o    (cr0_we_o),
  .cr0_o       (cr0_o),
  .xer_ca_o    (xer_ca_o),
  .xer_ca32_o  (xer_ca32_o),
  .xer_ov_o    (xer_ov_o),
  .xer_ov32_o  (xer_ov32_o),
  .xer_so_o    (xer_so_o)
);

// File: tb/test_fxadd_unit.sv
module test_fxadd_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [31:0] insn;
  logic [63:0] opa, opb;
  logic        m32, isa3;
  logic        res_valid, illegal, cr0_we;
  logic [63:0] res;
  logic [4:0]  rt;
  logic [3:0]  cr0;
  logic        ca, ca32, ov, ov32, so;

  logic m_ca, m_ca32, m_ov, m_ov32, m_so;
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  fxadd_unit i_fxadd_unit (
    .clk(clk), .rst(rst), .issue_i(issue), .insn_i(insn), .opa_i(opa), .opb_i(opb),
    .mode32_i(m32), .isa300_i(isa3), .res_valid_o(res_valid), .res_o(res), .rt_o(rt),
    .illegal_o(illegal), .cr0_we_o(cr0_we), .cr0_o(cr0), .xer_ca_o(ca), .xer_ca32_o(ca32),
    .xer_ov_o(ov), .xer_ov32_o(ov32), .xer_so_o(so)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xo_w(logic [9:0] x10, logic rc, logic [4:0] t);
    return {6'd31, t, 5'd1, 5'd2, x10, rc};
  endfunction

  function automatic logic [31:0] alt_w(logic [1:0] cy, logic rc, logic [4:0] t);
    return {6'd31, t, 5'd1, 5'd2, cy, 8'd170, rc};
  endfunction

  task automatic exec(string tag, logic iss, logic [31:0] ins, logic [63:0] a, logic [63:0] b,
                      logic md, logic lv);
    int          knd;
    logic        e_val, e_ill, e_we, cin, co, c32, s64, s32;
    logic [3:0]  e_cr;
    logic [63:0] bb, e_res, cv;
    logic [64:0] w;
    logic [32:0] wl;
    logic [4:0]  e_rt;
    logic        n_ca, n_ca32, n_ov, n_ov32, n_so;
    knd = -1;
    e_val = 0; e_ill = 0; e_we = 0; e_cr = 0; e_res = 0; e_rt = 0;
    n_ca = m_ca; n_ca32 = m_ca32; n_ov = m_ov; n_ov32 = m_ov32; n_so = m_so;
    if (iss && ins[31:26] == 6'd31) begin
      if (ins[8:1] == 8'd170) knd = 5;
      else case (ins[9:1])
        9'd266: knd = 0;
        9'd10:  knd = 1;
        9'd138: knd = 2;
        9'd234: knd = 3;
        9'd202: knd = 4;
        default: knd = -1;
      endcase
    end
    if (knd == 5 && (ins[10:9] != 2'd0 || ins[0] || !lv)) begin
      e_ill = 1;
      knd = -1;
    end
    if (knd >= 0) begin
      bb  = (knd == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : (knd == 4) ? 64'd0 : b;
      cin = (knd >= 2 && knd <= 4) ? m_ca : (knd == 5) ? m_ov : 1'b0;
      w   = {1'b0, a} + {1'b0, bb} + {64'd0, cin};
      wl  = {1'b0, a[31:0]} + {1'b0, bb[31:0]} + {32'd0, cin};
      co  = md ? wl[32] : w[64];
      c32 = wl[32];
      s64 = (a[63] == bb[63]) && (w[63] != a[63]);
      s32 = (a[31] == bb[31]) && (wl[31] != a[31]);
      e_val = 1; e_res = w[63:0]; e_rt = ins[25:21];
      if (knd >= 1 && knd <= 4) begin n_ca = co; if (lv) n_ca32 = c32; end
      if (knd == 5) begin n_ov = co; if (lv) n_ov32 = c32; end
      if (knd != 5 && ins[10]) begin
        n_ov = md ? s32 : s64;
        if (lv) n_ov32 = s32;
        if (n_ov) n_so = 1;
      end
      if (knd != 5 && ins[0]) begin
        e_we = 1;
        cv = md ? {{32{w[31]}}, w[31:0]} : w[63:0];
        e_cr = {cv[63], !cv[63] && cv != 0, cv == 0, n_so};
      end
    end
    @(negedge clk);
    issue = iss; insn = ins; opa = a; opb = b; m32 = md; isa3 = lv;
    @(posedge clk);
    #2;
    chk({tag, " result"}, res, e_res);
    chk({tag, " rt"}, {59'd0, rt}, {59'd0, e_rt});
    chk({tag, " flags"}, {51'd0, res_valid, illegal, cr0_we, cr0, ca, ca32, ov, ov32, so},
        {51'd0, e_val, e_ill, e_we, e_cr, n_ca, n_ca32, n_ov, n_ov32, n_so});
    m_ca = n_ca; m_ca32 = n_ca32; m_ov = n_ov; m_ov32 = n_ov32; m_so = n_so;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] ra, rb;
    logic [9:0]  x10;
    int          sel;
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0;
    rst = 1; issue = 0; insn = 0; opa = 0; opb = 0; m32 = 0; isa3 = 1;
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    chk("R9 reset", {res_valid, illegal, cr0_we, cr0, ca, ca32, ov, ov32, so, rt}, 0);
    chk("R9 reset result", res, 0);
    @(negedge clk); rst = 0;

    exec("R3 carry out of 64", 1, xo_w(10'd10, 0, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);
    exec("R4 plain add ignores carry", 1, xo_w(10'd266, 0, 5'd4), 64'd1, 64'd2, 0, 1);
    exec("R2 extended add", 1, xo_w(10'd138, 0, 5'd5), 64'd1, 64'd1, 0, 1);
    exec("R2 minus one", 1, xo_w(10'd234, 0, 5'd6), 64'd0, 64'd99, 0, 1);
    exec("R2 zero ext", 1, xo_w(10'd202, 0, 5'd7), 64'd5, 64'd99, 0, 1);
    exec("R7 signed ovf", 1, xo_w(10'd266 + 10'd512, 0, 5'd8), 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);
    exec("R5 alternate chain", 1, alt_w(2'd0, 0, 5'd9), 64'd1, 64'd1, 0, 1);
    exec("R5 alternate carry out", 1, alt_w(2'd0, 0, 5'd9), 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 1);
    exec("R6 cy nonzero", 1, alt_w(2'd1, 0, 5'd10), 64'd3, 64'd4, 0, 1);
    exec("R6 record bit", 1, alt_w(2'd0, 1, 5'd10), 64'd3, 64'd4, 0, 1);
    exec("R6 old isa", 1, alt_w(2'd0, 0, 5'd10), 64'd3, 64'd4, 0, 0);
    exec("R3 mode32 carry", 1, xo_w(10'd10, 0, 5'd11), 64'h0000_0000_FFFF_FFFF, 64'd1, 1, 1);
    exec("R3 old isa holds ca32", 1, xo_w(10'd10, 0, 5'd11), 64'd1, 64'd1, 0, 0);
    exec("R8 negative record", 1, xo_w(10'd266, 1, 5'd12), 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    exec("R8 mode32 zero", 1, xo_w(10'd266, 1, 5'd13), 64'h0000_0001_0000_0000, 64'd0, 1, 1);
    exec("R7 mode32 ovf", 1, xo_w(10'd266 + 10'd512, 1, 5'd14), 64'h7FFF_FFFF, 64'd1, 1, 1);
    exec("R1 other primary", 1, {6'd14, 26'h3ABCDEF}, 64'd1, 64'd1, 0, 1);
    exec("R1 other ext op", 1, xo_w(10'd40, 1, 5'd15), 64'd1, 64'd1, 0, 1);
    exec("R9 no issue", 0, xo_w(10'd10, 1, 5'd16), 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 0, 1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      sel = $urandom_range(0, 7);
      case (sel)
        0: x10 = 10'd266; 1: x10 = 10'd10; 2: x10 = 10'd138;
        3: x10 = 10'd234; 4: x10 = 10'd202; 5: x10 = {2'd0, 8'd170};
        6: x10 = {2'd0, 8'd170};
        default: x10 = 10'($urandom_range(0, 1023));
      endcase
      if (sel < 5 && $urandom_range(0, 1) == 1) x10[9] = 1'b1;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) ra = 64'h7FFF_FFFF_FFFF_FFFF;
      if ($urandom_range(0, 3) == 0) rb = 64'h0000_0000_FFFF_FFFF;
      exec("R2 random", 1,
           xo_w(x10, (sel >= 5) ? 1'b0 : 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31))),
           ra, rb, 1'($urandom_range(0, 1)), ($urandom_range(0, 5) != 0));
    end

    @(negedge clk); issue = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule